// File: doc/BRIEF.md
# ATA PIO Sector Transfer Sequencer

This block is the host side of a programmed-I/O disk transfer. User logic asks for a transfer by giving a 28-bit logical sector address, a sector count and a direction. The sequencer then runs the whole exchange on an ATA-style register bus. It loads the task file, issues the read-sectors or write-sectors command and polls the status register until the device asks for data. It then moves each sector as a burst of 16-bit data-register accesses and repeats the status poll before every further sector. When the transfer ends it raises a one-cycle completion pulse with a result code.

Data toward user logic leaves on a valid/ready word stream, and data from user logic enters on a second valid/ready stream. A slow consumer or producer simply holds the bus idle between accesses. Each register access is one strobe held low for a fixed number of clocks. Every status poll is bounded by a cycle budget, and when the budget runs out the transfer ends with a timeout result.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset `busy`, `done` and `rd_valid` are low, and `reg_cs_n`, `reg_rd_n` and `reg_wr_n` are all high.
- R2: A request writes, in this order, register 2 with the sector count, registers 3, 4 and 5 with address bits 7..0, 15..8 and 23..16, and register 6 with E0h OR address bits 27..24. Register 7 is written last with command 20h for a read or 30h for a write.
- R3: After the command, and again before each later sector, register 7 is read repeatedly. No data-register (register 0) access happens until a read of it returns exactly 58h.
- R4: Each sector is moved as exactly WORDS_PER_SEC (default 256) accesses to register 0. Read data reaches `rd_word` in the order it was read.
- R5: The number of sectors moved equals the requested count, with a separate status poll ahead of each sector.
- R6: After the last written sector, register 7 is read until it returns 50h, which ends with result 0 (ok), or 51h, which ends with result 1 (device error).
- R7: A poll read that is not 58h and has bit 0 set ends the transfer with result 1 and no data access.
- R8: A read transfer ends with result 0 once the last word of the last sector has been taken by the consumer.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_word` stays stable, and no new data read starts. A write word is taken only in a cycle where `wr_valid` and `wr_ready` are both high.
- R10: If a poll has lasted TMO_CYC cycles without an accepted status value, the transfer ends with result 2 (timeout) and the block returns to idle.
- R11: Every register strobe stays low for exactly STB_CYC cycles. The read and write strobes are never low together, and `reg_cs_n` is low while either strobe is low.
- R12: `done` is a single-cycle pulse and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken while idle |
| start_lba | input | 28 | Logical sector address of the first sector |
| start_count | input | 8 | Sector count (0 means 256) |
| start_write | input | 1 | 1 = write transfer, 0 = read transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 device error, 2 timeout; valid with `done` |
| reg_addr | output | 3 | Register select |
| reg_cs_n | output | 1 | Chip select, active low |
| reg_rd_n | output | 1 | Read strobe, active low |
| reg_wr_n | output | 1 | Write strobe, active low |
| reg_wdata | output | DW | Write data to the device |
| reg_wdata_oe | output | 1 | Drive enable for `reg_wdata` |
| reg_rdata | input | DW | Read data from the device |
| rd_word | output | DW | Word read from a sector |
| rd_valid | output | 1 | `rd_word` holds a word |
| rd_ready | input | 1 | Consumer takes the word |
| wr_word | input | DW | Word to be written |
| wr_valid | input | 1 | `wr_word` holds a word |
| wr_ready | output | 1 | Sequencer takes the word |

## Verification
The device model answers polls with a number of busy values before 58h, so a design that moves data before the exact ready code, or skips the poll before the second sector, is caught by the model's out-of-phase access count. Consumer and producer stalls are applied throughout the bursts. A design that drops, repeats or reorders words under back-pressure therefore fails the scoreboard. Final status values of 50h and 51h, a poll that returns an error code and a device that never becomes ready are each run. These catch a design that tests single bits instead of exact codes, or that hangs without a timeout. Strobe widths and the order of the task-file writes are measured from the bus itself.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd7;
  localparam logic [2:0] REG_FIRST  = 3'd2;
  localparam logic [7:0] CMD_READ   = 8'h20;
  localparam logic [7:0] CMD_WRITE  = 8'h30;
  localparam logic [7:0] STS_DRQ    = 8'h58;
  localparam logic [7:0] STS_OK     = 8'h50;
  localparam logic [7:0] STS_FAIL   = 8'h51;
  localparam logic [3:0] DH_UPPER   = 4'hE;
  localparam int         LBA_W      = 28;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_POLL, SQ_DATA, SQ_FINAL
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_DEV_ERR = 2'd1, RES_TIMEOUT = 2'd2
  } result_e;
endpackage

// File: rtl/ata_bus_cycle.sv
module ata_bus_cycle #(
  parameter int STB_CYC = 4,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_write,
  input  logic [2:0]    go_addr,
  input  logic [DW-1:0] go_data,
  output logic          ack,
  output logic [DW-1:0] rdata_q,
  output logic [2:0]    reg_addr,
  output logic          reg_cs_n,
  output logic          reg_rd_n,
  output logic          reg_wr_n,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wdata_oe,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;

  logic          active;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      left         <= '0;
      ack          <= 1'b0;
      rdata_q      <= '0;
      reg_addr     <= '0;
      reg_cs_n     <= 1'b1;
      reg_rd_n     <= 1'b1;
      reg_wr_n     <= 1'b1;
      reg_wdata    <= '0;
      reg_wdata_oe <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (!active) begin
        if (go) begin
          active   <= 1'b1;
          left     <= CW'(STB_CYC - 1);
          reg_addr <= go_addr;
          reg_cs_n <= 1'b0;
          if (go_write) begin
            reg_wr_n     <= 1'b0;
            reg_wdata    <= go_data;
            reg_wdata_oe <= 1'b1;
          end else begin
            reg_rd_n <= 1'b0;
          end
        end
      end else if (left == '0) begin
        if (!reg_rd_n) rdata_q <= reg_rdata;
        active       <= 1'b0;
        reg_cs_n     <= 1'b1;
        reg_rd_n     <= 1'b1;
        reg_wr_n     <= 1'b1;
        reg_wdata_oe <= 1'b0;
        ack          <= 1'b1;
      end else begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end else begin
      expired <= 1'b1;
    end
  end
endmodule

// File: rtl/ata_taskfile_map.sv
module ata_taskfile_map
  import ata_pio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]       step,
  input  logic [LBA_W-1:0] lba,
  input  logic [7:0]       count,
  input  logic             is_write,
  output logic [2:0]       addr,
  output logic [DW-1:0]    data
);
  logic [7:0] byte_v;

  always_comb begin
    unique case (step)
      3'd0:    byte_v = count;
      3'd1:    byte_v = lba[7:0];
      3'd2:    byte_v = lba[15:8];
      3'd3:    byte_v = lba[23:16];
      3'd4:    byte_v = {DH_UPPER, lba[27:24]};
      default: byte_v = is_write ? CMD_WRITE : CMD_READ;
    endcase
  end

  assign addr = REG_FIRST + step;
  assign data = DW'(byte_v);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int STB_CYC       = 4,
  parameter int TMO_CYC       = 100000,
  parameter int WORDS_PER_SEC = 256,
  parameter int DW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [27:0]   start_lba,
  input  logic [7:0]    start_count,
  input  logic          start_write,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [2:0]    reg_addr,
  output logic          reg_cs_n,
  output logic          reg_rd_n,
  output logic          reg_wr_n,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wdata_oe,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] rd_word,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic [DW-1:0] wr_word,
  input  logic          wr_valid,
  output logic          wr_ready
);
  localparam int WCW = (WORDS_PER_SEC > 1) ? $clog2(WORDS_PER_SEC) : 1;

  seq_state_e       state;
  logic             pend;
  logic [2:0]       step;
  logic [WCW-1:0]   wcnt;
  logic [8:0]       left;
  logic [LBA_W-1:0] lba_q;
  logic [7:0]       cnt_q;
  logic             wdir;

  logic             go, go_wr, ack, expired, word_done;
  logic [2:0]       go_addr, map_addr;
  logic [DW-1:0]    go_data, map_data, bus_rdata;
  logic [7:0]       stat;

  ata_taskfile_map #(.DW(DW)) u_map (
    .step(step), .lba(lba_q), .count(cnt_q), .is_write(wdir),
    .addr(map_addr), .data(map_data)
  );

  ata_bus_cycle #(.STB_CYC(STB_CYC), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .go(go), .go_write(go_wr), .go_addr(go_addr),
    .go_data(go_data), .ack(ack), .rdata_q(bus_rdata),
    .reg_addr(reg_addr), .reg_cs_n(reg_cs_n), .reg_rd_n(reg_rd_n),
    .reg_wr_n(reg_wr_n), .reg_wdata(reg_wdata), .reg_wdata_oe(reg_wdata_oe),
    .reg_rdata(reg_rdata)
  );

  ata_poll_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .en(state == SQ_POLL || state == SQ_FINAL),
    .expired(expired)
  );

  assign busy      = (state != SQ_IDLE);
  assign stat      = bus_rdata[7:0];
  assign word_done = wdir ? ack : (rd_valid && rd_ready);

  // access issue: one bus cycle at a time, only when none is pending
  always_comb begin
    go       = 1'b0;
    go_wr    = 1'b0;
    go_addr  = REG_STATUS;
    go_data  = '0;
    wr_ready = 1'b0;
    unique case (state)
      SQ_SETUP: if (!pend) begin
        go = 1'b1; go_wr = 1'b1; go_addr = map_addr; go_data = map_data;
      end
      SQ_POLL, SQ_FINAL: if (!pend) go = 1'b1;
      SQ_DATA: if (!pend) begin
        if (wdir) begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            go = 1'b1; go_wr = 1'b1; go_addr = REG_DATA; go_data = wr_word;
          end
        end else if (!rd_valid) begin
          go = 1'b1; go_addr = REG_DATA;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      pend     <= 1'b0;
      step     <= '0;
      wcnt     <= '0;
      left     <= '0;
      lba_q    <= '0;
      cnt_q    <= '0;
      wdir     <= 1'b0;
      done     <= 1'b0;
      result   <= RES_OK;
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      done <= 1'b0;
      if (go)       pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          lba_q <= start_lba;
          cnt_q <= start_count;
          wdir  <= start_write;
          left  <= (start_count == 8'd0) ? 9'd256 : {1'b0, start_count};
          step  <= '0;
          state <= SQ_SETUP;
        end
        SQ_SETUP: if (ack) begin
          if (step == 3'd5) state <= SQ_POLL;
          else              step  <= step + 1'b1;
        end
        SQ_POLL: if (ack) begin
          if (stat == STS_DRQ) begin
            state <= SQ_DATA;
            wcnt  <= '0;
          end else if (stat[0]) begin
            state <= SQ_IDLE; done <= 1'b1; result <= RES_DEV_ERR;
          end else if (expired) begin
            state <= SQ_IDLE; done <= 1'b1; result <= RES_TIMEOUT;
          end
        end
        SQ_DATA: begin
          if (!wdir && ack) begin
            rd_word  <= bus_rdata;
            rd_valid <= 1'b1;
          end
          if (rd_valid && rd_ready) rd_valid <= 1'b0;
          if (word_done) begin
            if (wcnt == WCW'(WORDS_PER_SEC - 1)) begin
              left <= left - 1'b1;
              if (left != 9'd1) begin
                state <= SQ_POLL;
              end else if (wdir) begin
                state <= SQ_FINAL;
              end else begin
                state <= SQ_IDLE; done <= 1'b1; result <= RES_OK;
              end
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        SQ_FINAL: if (ack) begin
          if (stat == STS_OK) begin
            state <= SQ_IDLE; done <= 1'b1; result <= RES_OK;
          end else if (stat == STS_FAIL) begin
            state <= SQ_IDLE; done <= 1'b1; result <= RES_DEV_ERR;
          end else if (expired) begin
            state <= SQ_IDLE; done <= 1'b1; result <= RES_TIMEOUT;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
  parameter int STB_CYC = 4,
  parameter int DW      = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_cs_n,
  input logic          reg_rd_n,
  input logic          reg_wr_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_word,
  input logic          done,
  input logic          busy,
  input logic [1:0]    result
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                      low_cnt <= '0;
    else if (reg_rd_n & reg_wr_n) low_cnt <= '0;
    else                          low_cnt <= low_cnt + 1'b1;
  end

  a_r11_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rd_n & reg_wr_n) |-> (low_cnt == 16'(STB_CYC)));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!reg_rd_n && !reg_wr_n));

  a_r11_cs_framing: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd_n || !reg_wr_n) |-> !reg_cs_n);

  a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_word)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_result_code: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'd3));
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.STB_CYC(STB_CYC), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .reg_cs_n(reg_cs_n), .reg_rd_n(reg_rd_n),
  .reg_wr_n(reg_wr_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_word(rd_word), .done(done), .busy(busy), .result(result)
);

// File: tb/sim_ata_pio_seq.sv
`timescale 1ns/1ps
module sim_ata_pio_seq;
  localparam int STB = 3;
  localparam int TMO = 400;
  localparam int WPS = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [27:0] start_lba = '0;
  logic [7:0]  start_count = '0;
  logic        start_write = 1'b0;
  logic        busy, done;
  logic [1:0]  result;
  logic [2:0]  reg_addr;
  logic        reg_cs_n, reg_rd_n, reg_wr_n, reg_wdata_oe;
  logic [15:0] reg_wdata, reg_rdata, rd_word;
  logic        rd_valid, wr_ready;
  logic        rd_ready = 1'b0;
  logic [15:0] wr_word = '0;
  logic        wr_valid = 1'b0;

  ata_pio_seq #(.STB_CYC(STB), .TMO_CYC(TMO), .WORDS_PER_SEC(WPS), .DW(16)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_lba(start_lba),
    .start_count(start_count), .start_write(start_write), .busy(busy),
    .done(done), .result(result), .reg_addr(reg_addr), .reg_cs_n(reg_cs_n),
    .reg_rd_n(reg_rd_n), .reg_wr_n(reg_wr_n), .reg_wdata(reg_wdata),
    .reg_wdata_oe(reg_wdata_oe), .reg_rdata(reg_rdata), .rd_word(rd_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_word(wr_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];

  function automatic logic [15:0] rval(int sec, int w);
    return {8'(sec) ^ 8'hA5, 8'(w)};
  endfunction
  function automatic logic [15:0] wval(int i);
    return 16'(i * 16'h0107) ^ 16'h3C5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int   m_mode = 0;        // 0 normal, 1 poll error, 2 never ready
  int   m_polls_cfg = 0;
  logic [7:0] m_final = 8'h50;
  int   m_phase = 0;       // 0 idle, 1 polling, 2 data, 3 final status
  int   m_busy_left = 0, m_sec = 0, m_word = 0, m_nsec = 0;
  int   m_viol = 0, m_dacc = 0, m_sb_err = 0;
  logic [7:0] tf [0:7];
  int   log_addr [0:15];
  int   log_n = 0;
  logic prev_rd = 1'b1, prev_wr = 1'b1;

  logic [7:0] m_status;
  always_comb begin
    if (m_mode == 2)                          m_status = 8'h80;
    else if (m_phase == 1 && m_busy_left > 0) m_status = 8'h80;
    else if (m_phase == 1)                    m_status = (m_mode == 1) ? 8'h51 : 8'h58;
    else if (m_phase == 2)                    m_status = 8'h58;
    else if (m_phase == 3)                    m_status = m_final;
    else                                      m_status = 8'h50;
    if (reg_addr == 3'd7)      reg_rdata = {8'h00, m_status};
    else if (reg_addr == 3'd0) reg_rdata = rval(m_sec, m_word);
    else                       reg_rdata = {8'h00, tf[reg_addr]};
  end

  task automatic data_step();
    m_dacc++;
    if (m_phase != 2) m_viol++;
    if (m_word == WPS - 1) begin
      m_word = 0;
      m_sec++;
      if (m_sec == m_nsec) m_phase = (m_phase == 2 && start_write) ? 3 : 0;
      else begin m_phase = 1; m_busy_left = m_polls_cfg; end
    end else m_word++;
  endtask

  always @(posedge clk) begin
    if (!prev_wr && reg_wr_n) begin
      if (log_n < 16) begin log_addr[log_n] = int'(reg_addr); log_n++; end
      if (reg_addr == 3'd0) begin
        if (exp_q.size() == 0 || exp_q[0] != reg_wdata) m_sb_err++;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        data_step();
      end else begin
        tf[reg_addr] = reg_wdata[7:0];
        if (reg_addr == 3'd7) begin
          m_phase = 1; m_busy_left = m_polls_cfg; m_sec = 0; m_word = 0;
          m_nsec = (tf[2] == 8'd0) ? 256 : int'(tf[2]);
        end
      end
    end
    if (!prev_rd && reg_rd_n) begin
      if (reg_addr == 3'd7 && m_phase == 1) begin
        if (m_busy_left > 0) m_busy_left--;
        else if (m_mode == 0) m_phase = 2;
      end else if (reg_addr == 3'd0) data_step();
    end
    prev_rd = reg_rd_n;
    prev_wr = reg_wr_n;
  end

  // ---------------- stream driver and monitors ----------------
  int  cyc = 0;
  int  src_i = 0;
  bit  wr_en = 0;
  bit  neg_acc = 0;
  int  hold_viol = 0;
  bit  hold_pend = 0;
  logic [15:0] hold_word;
  int  stb_low = 0, stb_bad = 0, stb_seen = 0, bus_bad = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (neg_acc) src_i++;
    rd_ready <= (cyc % 4) != 2;
    wr_valid <= wr_en && ((cyc % 3) != 1);
    wr_word  <= wval(neg_acc ? src_i : src_i);
  end

  always @(negedge clk) begin
    neg_acc = wr_valid && wr_ready;
    // R9: held word stays put while the consumer stalls
    if (hold_pend && !(rd_valid && rd_word == hold_word)) hold_viol++;
    hold_pend = rd_valid && !rd_ready;
    hold_word = rd_word;
    // scoreboard monitor for read data (R4)
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0 || exp_q[0] != rd_word) m_sb_err++;
      if (exp_q.size() != 0) void'(exp_q.pop_front());
    end
    // R11: strobe width and bus framing seen from the pins
    if (!reg_rd_n && !reg_wr_n) bus_bad++;
    if ((!reg_rd_n || !reg_wr_n) && reg_cs_n) bus_bad++;
    if (!reg_rd_n || !reg_wr_n) stb_low++;
    else if (stb_low != 0) begin
      stb_seen++;
      if (stb_low != STB) stb_bad++;
      stb_low = 0;
    end
  end

  // ---------------- test sequencing ----------------
  bit hung = 0;

  task automatic run(input logic [27:0] lba, input int cnt, input bit wr,
                     input int polls, input int mode, input logic [7:0] fin,
                     input int exp_res, input string req);
    int waited;
    int words;
    words = (mode == 0) ? cnt * WPS : 0;
    m_mode = mode; m_polls_cfg = polls; m_final = fin;
    m_viol = 0; m_dacc = 0; m_sb_err = 0; log_n = 0;
    exp_q.delete();
    src_i = 0;
    for (int i = 0; i < words; i++) exp_q.push_back(wr ? wval(i) : rval(i / WPS, i % WPS));
    wr_en = wr;
    @(negedge clk);
    start = 1'b1; start_lba = lba; start_count = 8'(cnt); start_write = wr;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 40000) begin @(negedge clk); waited++; end
    if (!done) begin
      hung = 1;
      check(0, req, "watchdog: no done", 0, 1);
      return;
    end
    check(result == 2'(exp_res), req, "result", int'(result), exp_res);
    check(!busy, "R12", "busy during done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R12", "done longer than one cycle", int'(done), 0);
    check(m_viol == 0, "R3", "data access before 58h", m_viol, 0);
    check(m_dacc == words, "R5", "data access count", m_dacc, words);
    check(exp_q.size() == 0 && m_sb_err == 0, "R4", "scoreboard mismatches",
          m_sb_err + exp_q.size(), 0);
    if (log_n >= 6) begin
      for (int k = 0; k < 6; k++)
        check(log_addr[k] == k + 2, "R2", "task-file write order", log_addr[k], k + 2);
      check(tf[2] == 8'(cnt), "R2", "count register", tf[2], cnt);
      check(tf[3] == lba[7:0], "R2", "address low", tf[3], lba[7:0]);
      check(tf[4] == lba[15:8], "R2", "address mid", tf[4], lba[15:8]);
      check(tf[5] == lba[23:16], "R2", "address high", tf[5], lba[23:16]);
      check(tf[6] == {4'hE, lba[27:24]}, "R2", "drive/head", tf[6], {4'hE, lba[27:24]});
      check(tf[7] == (wr ? 8'h30 : 8'h20), "R2", "command", tf[7], wr ? 8'h30 : 8'h20);
    end else check(0, "R2", "task-file write count", log_n, 6);
    wr_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tf[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !rd_valid, "R1", "busy/done/rd_valid", {busy, done, rd_valid}, 0);
    check(reg_cs_n && reg_rd_n && reg_wr_n, "R1", "bus idle", {reg_cs_n, reg_rd_n, reg_wr_n}, 3'b111);
    rst = 1'b0;
    @(negedge clk);
    // R8 R4 R5 R9: two-sector read with busy polls and consumer stalls
    run(28'h5A3C1D2, 2, 1'b0, 3, 0, 8'h50, 0, "R8");
    if (!hung) check(hold_viol == 0, "R9", "held read word changed", hold_viol, 0);
    // R6: three-sector write ending with 50h, then a write ending with 51h
    if (!hung) run(28'h0123456, 3, 1'b1, 2, 0, 8'h50, 0, "R6");
    if (!hung) run(28'hFEDCBA9, 1, 1'b1, 0, 0, 8'h51, 1, "R6");
    // R7: poll reports an error code
    if (!hung) run(28'h0000777, 2, 1'b0, 1, 1, 8'h50, 1, "R7");
    // R10: device never becomes ready
    if (!hung) run(28'h1111111, 1, 1'b0, 0, 2, 8'h50, 2, "R10");
    if (!hung) check(!busy, "R10", "idle after timeout", int'(busy), 0);
    // R11: strobe width and framing measured at the pins
    check(stb_seen > 0 && stb_bad == 0, "R11", "strobe width errors", stb_bad, 0);
    check(bus_bad == 0, "R11", "strobe overlap or cs high", bus_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule